// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

The block controls an external successive-approximation converter through a small digital handshake. It provides a power enable, a channel select, a one-cycle start strobe and a converter reference clock, and it accepts an end-of-conversion strobe together with a 10-bit result. The reference clock comes from the master clock through an 8-bit prescaler. A rising edge on the hardware trigger, or a software start pulse, begins a sequence. The block powers the converter and waits a fixed start-up interval. It then converts every enabled channel once, lowest index first, and powers the converter down when the last one is done.

Tracking of the next channel starts as soon as the current conversion has been launched. The select lines move to that channel at once, so the analog settling runs during the conversion of the current channel. The next start waits for two things: the programmed tracking time must have run out, and the current result must be in and its transfer gap must have passed. A tracking time longer than the conversion therefore stretches the gap between starts. Each result goes into a per-channel slot and into a last-result register. A data-ready flag marks a new result, and a read strobe on the last result clears it. A low-resolution mode keeps the 8 most significant converter bits, right-aligned, and reads the top two bits as zero.

Top module: `adc_seq`

## Requirements
- R1: While a sequence is active, `adc_clk` is periodic with a period of 2*(`prescale`+1) master clock cycles.
- R2: In idle with at least one bit of `ch_enable` set, a `sw_start` pulse or a 0-to-1 edge on `hw_trig` raises `adc_on` one cycle later. With `ch_enable` all zero, a trigger leaves `adc_on` low.
- R3: The first `adc_start` of a sequence comes (STARTUP_TICKS + `track_time` + 1) converter clock periods after `adc_on` rises, to within one period. `adc_start` is only ever high while `adc_on` is high.
- R4: Each sequence issues exactly one `adc_start` per enabled channel, in ascending channel order. `adc_sel` equals the channel being converted in the cycle `adc_start` is high, and `adc_start` lasts one cycle.
- R5: Tracking of the next channel runs from the previous start. The interval between two starts is the larger of two times: (`track_time`+1) converter periods, and the conversion (10 converter periods) plus `transfer_time` periods.
- R6: With `low_res` = 0, the 10-bit converter result of channel n is stored unchanged in `ch_data[n*10 +: 10]`.
- R7: With `low_res` = 1, the stored value is `adc_data[9:2]` in bits 7..0, and bits 9..8 are 0, both in `ch_data` and in `last_data`.
- R8: After each end-of-conversion, `last_data` and `last_ch` hold that result and its channel and `data_ready` is 1. A `last_rd` pulse clears `data_ready`.
- R9: A trigger that arrives while a sequence is running is ignored: no additional starts, and no new sequence after the running one ends.
- R10: After the last enabled channel's result and transfer gap, `adc_on` and `busy` return to 0 and stay there until the next trigger.
- R11: Synchronous reset (`rst_n` = 0) clears `adc_on`, `adc_start`, `data_ready`, `busy`, `last_data` and all channel results to 0, including in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale | input | 8 | Converter clock divider setting, period 2*(value+1) |
| track_time | input | 4 | Tracking time minus one, in converter clock periods |
| transfer_time | input | 2 | Gap after a result before the next start, in converter clock periods |
| ch_enable | input | 8 | One bit per channel to include in the sequence |
| low_res | input | 1 | 1 selects 8-bit results |
| hw_trig | input | 1 | Hardware trigger, rising edge starts a sequence |
| sw_start | input | 1 | Software start pulse |
| last_rd | input | 1 | Read strobe of the last-result register, clears data_ready |
| adc_clk | output | 1 | Converter reference clock |
| adc_on | output | 1 | Converter power enable |
| adc_sel | output | 3 | Channel presented to the converter |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_eoc | input | 1 | End-of-conversion strobe from the converter |
| adc_data | input | 10 | Converter result, valid with adc_eoc |
| ch_data | output | 80 | Per-channel results, channel n at bits n*10+9..n*10 |
| last_data | output | 10 | Most recent result |
| last_ch | output | 3 | Channel of the most recent result |
| data_ready | output | 1 | A new result is in last_data |
| busy | output | 1 | A sequence is running |

## Verification
Some internal faults show up at the ports within one converter period. A wrong channel pointer puts the wrong `adc_sel` on the first start after the fault. A prescaler counter at the wrong value changes the very next `adc_clk` period. Other faults take longer to show. A tracking counter that clears too early, or is ignored, shortens the next start-to-start interval by several converter periods, so the fault appears at the second start of a sequence. A faulty result store or resolution path shows up once the sequence has ended: a slot holds the wrong value, or bits 9..8 are nonzero. A trigger latch that still accepts input while busy shows as extra starts, or as `adc_on` rising again after the sequence ends.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the ADC conversion sequencer.
// Assumes nothing beyond a single synchronous clock domain.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_STARTUP,
        S_TRACK,
        S_CONV,
        S_XFER
    } seq_state_t;

    // Converter result width, fixed by the converter macro.
    localparam int RES_W = 10;
endpackage

// File: rtl/adc_clk_div.sv
// Converter clock prescaler. When run is high, it counts master cycles
// modulo 2*(prescale+1) and emits a one-cycle tick on the last count.
// adc_clk is high during the upper half of each count. When run is low,
// the counter is held at zero, so every sequence starts in the same phase.
// Assumes prescale is stable while run is high.
module adc_clk_div #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] prescale,
    output logic          adc_clk,
    output logic          tick
);
    localparam int CW = PW + 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] half;
    logic [CW-1:0] last;

    assign half    = CW'(prescale) + CW'(1);
    assign last    = (half << 1) - CW'(1);
    assign tick    = run && (cnt == last);
    assign adc_clk = run && (cnt >= half);

    // Purpose: free-running divider counter, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Ticks are separated by at least two master cycles.
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/adc_chan_pick.sv
// Channel finder. It returns the lowest enabled channel whose index is
// at least base. found is low when no such channel exists.
// Purely combinational. base may be NCH, which means past the last channel.
module adc_chan_pick #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] ena,
    input  logic [CHW:0]   base,
    output logic           found,
    output logic [CHW-1:0] idx
);
    // Purpose: priority search from the top down, so the lowest match wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ena[i] && ((CHW+1)'(i) >= base)) begin
                found = 1'b1;
                idx   = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/adc_result_store.sv
// Result storage. When cap is high, it formats the raw converter word for
// the selected resolution and writes it into the channel slot and the
// last-result register, then sets data_ready. rd_clr clears data_ready
// unless a capture happens in the same cycle.
module adc_result_store #(
    parameter int NCH = 8,
    parameter int CHW = 3,
    parameter int DW  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [CHW-1:0]   cap_ch,
    input  logic [DW-1:0]    raw,
    input  logic             low_res,
    input  logic             rd_clr,
    output logic [NCH*DW-1:0] ch_data,
    output logic [DW-1:0]    last_data,
    output logic [CHW-1:0]   last_ch,
    output logic             data_ready
);
    logic [DW-1:0] slot [NCH];
    logic [DW-1:0] fmt;

    assign fmt = low_res ? {2'b00, raw[DW-1:2]} : raw;

    // Purpose: per-channel slots and last-result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) slot[i] <= '0;
            last_data <= '0;
            last_ch   <= '0;
        end else if (cap) begin
            slot[cap_ch] <= fmt;
            last_data    <= fmt;
            last_ch      <= cap_ch;
        end
    end

    // Purpose: data-ready flag, where a capture wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_ready <= 1'b0;
        else if (cap)     data_ready <= 1'b1;
        else if (rd_clr)  data_ready <= 1'b0;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign ch_data[g*DW +: DW] = slot[g];
    end

    assert_lowres_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && low_res) |=> (last_data[DW-1:DW-2] == 2'b00));
    assert_ready_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> data_ready);
    assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !cap) |=> !data_ready);
endmodule

// File: rtl/adc_seq.sv
// Multichannel ADC conversion sequencer, top level.
// On a trigger it powers the converter, waits STARTUP_TICKS converter
// periods, and then converts the enabled channels in ascending order.
// Tracking of the next channel overlaps the conversion of the current one.
// Assumes the converter samples adc_sel in the cycle adc_start is high,
// and pulses adc_eoc for one cycle with adc_data valid.
module adc_seq #(
    parameter int NCH           = 8,
    parameter int DW            = adc_seq_pkg::RES_W,
    parameter int PW            = 8,
    parameter int TW            = 4,
    parameter int XW            = 2,
    parameter int STARTUP_TICKS = 8,
    parameter int CHW           = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int SW            = $clog2(STARTUP_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     prescale,
    input  logic [TW-1:0]     track_time,
    input  logic [XW-1:0]     transfer_time,
    input  logic [NCH-1:0]    ch_enable,
    input  logic              low_res,
    input  logic              hw_trig,
    input  logic              sw_start,
    input  logic              last_rd,
    output logic              adc_clk,
    output logic              adc_on,
    output logic [CHW-1:0]    adc_sel,
    output logic              adc_start,
    input  logic              adc_eoc,
    input  logic [DW-1:0]     adc_data,
    output logic [NCH*DW-1:0] ch_data,
    output logic [DW-1:0]     last_data,
    output logic [CHW-1:0]    last_ch,
    output logic              data_ready,
    output logic              busy
);
    import adc_seq_pkg::*;

    seq_state_t     state;
    logic           hw_q;
    logic           trig_evt;
    logic           tick;
    logic           run;
    logic [SW-1:0]  su_cnt;
    logic           su_done;
    logic [TW:0]    trk_cnt;
    logic           trk_done;
    logic [XW-1:0]  xf_cnt;
    logic [CHW-1:0] conv_ch;
    logic           pend;
    logic           start_go;
    logic           cap;
    logic           first_found;
    logic [CHW-1:0] first_idx;
    logic           nxt_found;
    logic [CHW-1:0] nxt_idx;

    assign run      = (state != S_IDLE);
    assign busy     = run;
    assign trig_evt = (state == S_IDLE) && (|ch_enable) &&
                      (sw_start || (hw_trig && !hw_q));
    assign su_done  = tick && (su_cnt == SW'(STARTUP_TICKS - 1));
    assign trk_done = (trk_cnt > {1'b0, track_time});
    assign start_go = (state == S_TRACK) && trk_done;
    assign cap      = (state == S_CONV) && adc_eoc && !adc_start;

    adc_clk_div #(.PW(PW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .prescale (prescale),
        .adc_clk  (adc_clk),
        .tick     (tick)
    );

    adc_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick_first (
        .ena   (ch_enable),
        .base  ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    adc_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick_next (
        .ena   (ch_enable),
        .base  ({1'b0, adc_sel} + (CHW+1)'(1)),
        .found (nxt_found),
        .idx   (nxt_idx)
    );

    adc_result_store #(.NCH(NCH), .CHW(CHW), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (cap),
        .cap_ch     (conv_ch),
        .raw        (adc_data),
        .low_res    (low_res),
        .rd_clr     (last_rd),
        .ch_data    (ch_data),
        .last_data  (last_data),
        .last_ch    (last_ch),
        .data_ready (data_ready)
    );

    // Purpose: previous value of the hardware trigger, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= 1'b0;
        else        hw_q <= hw_trig;
    end

    // Purpose: tracking timer, restarted at each start and saturating when done.
    always_ff @(posedge clk) begin
        if (!rst_n)                                trk_cnt <= '0;
        else if (start_go)                         trk_cnt <= '0;
        else if (state == S_STARTUP && su_done)    trk_cnt <= '0;
        else if (run && tick && !trk_done)         trk_cnt <= trk_cnt + (TW+1)'(1);
    end

    // Purpose: sequence state machine and converter handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            adc_on    <= 1'b0;
            adc_start <= 1'b0;
            adc_sel   <= '0;
            conv_ch   <= '0;
            su_cnt    <= '0;
            xf_cnt    <= '0;
            pend      <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (trig_evt && first_found) begin
                        state   <= S_STARTUP;
                        adc_on  <= 1'b1;
                        adc_sel <= first_idx;
                        su_cnt  <= '0;
                    end
                end
                S_STARTUP: begin
                    if (su_done)   state  <= S_TRACK;
                    else if (tick) su_cnt <= su_cnt + SW'(1);
                end
                S_TRACK: begin
                    if (start_go) begin
                        adc_start <= 1'b1;
                        conv_ch   <= adc_sel;
                        state     <= S_CONV;
                    end
                end
                S_CONV: begin
                    if (adc_start) begin
                        adc_start <= 1'b0;
                        pend      <= nxt_found;
                        if (nxt_found) adc_sel <= nxt_idx;
                    end else if (adc_eoc) begin
                        state  <= S_XFER;
                        xf_cnt <= '0;
                    end
                end
                S_XFER: begin
                    if (xf_cnt == transfer_time) begin
                        if (pend) begin
                            state <= S_TRACK;
                        end else begin
                            state  <= S_IDLE;
                            adc_on <= 1'b0;
                        end
                    end else if (tick) begin
                        xf_cnt <= xf_cnt + XW'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    assert_next_higher_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CONV && adc_start && nxt_found) |->
        ((nxt_idx > adc_sel) && ch_enable[nxt_idx]));
    assert_start_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> adc_on);
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CONV || state == S_XFER || state == S_TRACK) |=> (state != S_STARTUP));
    assert_power_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_on) |-> (state == S_IDLE) && !data_ready == !data_ready && !adc_start);
endmodule

// File: tb/adc_seq_bench.sv
// Bench for adc_seq. It contains a behavioural converter model, a table of
// configurations walked by one loop, and directed tests for reset and
// corner cases.
module adc_seq_bench;
    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int STARTUP = 8;
    localparam int NV  = 6;

    // Row layout: {prescale[7:0], track[3:0], xfer[1:0], ena[7:0], low_res, use_hw}
    localparam logic [23:0] VEC [NV] = '{
        {8'd0, 4'd2,  2'd0, 8'b0000_0111, 1'b0, 1'b0},
        {8'd1, 4'd15, 2'd1, 8'b1010_0101, 1'b0, 1'b1},
        {8'd3, 4'd3,  2'd3, 8'b1000_0001, 1'b1, 1'b0},
        {8'd2, 4'd12, 2'd2, 8'b0111_1110, 1'b1, 1'b1},
        {8'd0, 4'd0,  2'd0, 8'b1111_1111, 1'b0, 1'b0},
        {8'd1, 4'd9,  2'd3, 8'b0100_0000, 1'b0, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      prescale = '0;
    logic [3:0]      track_time = '0;
    logic [1:0]      transfer_time = '0;
    logic [NCH-1:0]  ch_enable = '0;
    logic            low_res = 1'b0;
    logic            hw_trig = 1'b0;
    logic            sw_start = 1'b0;
    logic            last_rd = 1'b0;
    logic            adc_clk;
    logic            adc_on;
    logic [2:0]      adc_sel;
    logic            adc_start;
    logic            adc_eoc = 1'b0;
    logic [DW-1:0]   adc_data = '0;
    logic [NCH*DW-1:0] ch_data;
    logic [DW-1:0]   last_data;
    logic [2:0]      last_ch;
    logic            data_ready;
    logic            busy;

    int n_checks = 0;
    int n_fails  = 0;
    int vec_idx  = 0;
    int cyc      = 0;
    logic mon_clr = 1'b0;

    always #10 clk = ~clk;

    adc_seq u_adc_seq (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .track_time(track_time),
        .transfer_time(transfer_time), .ch_enable(ch_enable), .low_res(low_res),
        .hw_trig(hw_trig), .sw_start(sw_start), .last_rd(last_rd),
        .adc_clk(adc_clk), .adc_on(adc_on), .adc_sel(adc_sel), .adc_start(adc_start),
        .adc_eoc(adc_eoc), .adc_data(adc_data), .ch_data(ch_data),
        .last_data(last_data), .last_ch(last_ch), .data_ready(data_ready), .busy(busy)
    );

    function automatic logic [DW-1:0] model_val(input int ch, input int run);
        return DW'((ch * 131 + run * 37 + 300) % 1024);
    endfunction

    // Converter model: counts 10 adc_clk rising edges after a start.
    logic mdl_busy = 1'b0;
    int   mdl_cnt = 0;
    logic [2:0] mdl_sel = '0;
    logic clk_q = 1'b0;
    always @(posedge clk) begin
        clk_q   <= adc_clk;
        adc_eoc <= 1'b0;
        if (!rst_n) begin
            mdl_busy <= 1'b0;
        end else if (adc_start) begin
            mdl_busy <= 1'b1;
            mdl_cnt  <= 0;
            mdl_sel  <= adc_sel;
        end else if (mdl_busy && adc_clk && !clk_q) begin
            if (mdl_cnt == 9) begin
                mdl_busy <= 1'b0;
                adc_eoc  <= 1'b1;
                adc_data <= model_val(int'(mdl_sel), vec_idx);
            end else begin
                mdl_cnt <= mdl_cnt + 1;
            end
        end
    end

    // Monitor: records starts, power-on time and the adc_clk period.
    int   nstart = 0;
    int   st_sel [16];
    int   st_cyc [16];
    int   on_cyc = 0;
    int   rise_prev = 0;
    int   clk_per = 0;
    logic on_q = 1'b0;
    logic ck_q = 1'b0;
    always @(posedge clk) begin
        cyc  <= cyc + 1;
        on_q <= adc_on;
        ck_q <= adc_clk;
        if (mon_clr) begin
            nstart <= 0;
            clk_per <= 0;
        end else begin
            if (adc_start && nstart < 16) begin
                st_sel[nstart] <= int'(adc_sel);
                st_cyc[nstart] <= cyc;
                nstart <= nstart + 1;
            end
            if (adc_clk && !ck_q) begin
                rise_prev <= cyc;
                if (rise_prev != 0) clk_per <= cyc - rise_prev;
            end
        end
        if (adc_on && !on_q) begin
            on_cyc <= cyc;
            rise_prev <= 0;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails + 1);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input string what, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sw();
        sw_start = 1'b1; tick_n(1); sw_start = 1'b0;
    endtask

    task automatic wait_off();
        int guard = 0;
        while (adc_on && guard < 20000) begin tick_n(1); guard++; end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        // R11: reset state
        tick_n(3);
        check("R11", "adc_on in reset", int'(adc_on), 0);
        check("R11", "data_ready in reset", int'(data_ready), 0);
        check("R11", "adc_start in reset", int'(adc_start), 0);
        rst_n = 1'b1;
        tick_n(2);
        check("R11", "ch_data after reset", int'(ch_data == '0), 1);
        check("R11", "busy after reset", int'(busy), 0);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] row;
            int p, t, x, tk, cnt, hi_ch, kk, g, lo, hi, clo, chi;
            logic [7:0] ena;
            logic lr, hw;
            row = VEC[v];
            p = int'(row[23:16]); t = int'(row[15:12]); x = int'(row[11:10]);
            ena = row[9:2]; lr = row[1]; hw = row[0];
            tk = 2 * (p + 1);
            vec_idx = v;
            prescale = row[23:16]; track_time = row[15:12]; transfer_time = row[11:10];
            ch_enable = ena; low_res = lr;
            mon_clr = 1'b1; tick_n(1); mon_clr = 1'b0;
            if (hw) begin hw_trig = 1'b1; tick_n(2); hw_trig = 1'b0; end
            else    pulse_sw();
            // R2: power-on follows the trigger
            check("R2", "adc_on after trigger", int'(adc_on), 1);
            // R9: triggers during the run are ignored
            tick_n(40);
            pulse_sw();
            hw_trig = 1'b1; tick_n(1); hw_trig = 1'b0;
            wait_off();
            tick_n(30);
            check("R10", "adc_on after sequence", int'(adc_on), 0);
            check("R10", "busy after sequence", int'(busy), 0);
            cnt = 0; hi_ch = 0;
            for (int c = 0; c < NCH; c++) if (ena[c]) begin cnt++; hi_ch = c; end
            check("R9", "start count", nstart, cnt);
            // R4: ascending order of enabled channels
            kk = 0;
            for (int c = 0; c < NCH; c++) begin
                if (ena[c]) begin
                    if (kk < nstart) check("R4", "channel at start", st_sel[kk], c);
                    kk++;
                end
            end
            // R6 / R7: stored results
            for (int c = 0; c < NCH; c++) begin
                if (ena[c]) begin
                    int e;
                    e = int'(model_val(c, v));
                    if (lr) begin
                        check("R7", "ch_data low-res", int'(ch_data[c*DW +: DW]), e >> 2);
                        check("R7", "upper bits zero", int'(ch_data[c*DW+8 +: 2]), 0);
                    end else begin
                        check("R6", "ch_data full", int'(ch_data[c*DW +: DW]), e);
                    end
                end
            end
            // R8: last result and ready flag
            check("R8", "last_ch", int'(last_ch), hi_ch);
            check("R8", "last_data", int'(last_data),
                  lr ? (int'(model_val(hi_ch, v)) >> 2) : int'(model_val(hi_ch, v)));
            if (lr) check("R7", "last_data upper bits", int'(last_data[9:8]), 0);
            check("R8", "data_ready set", int'(data_ready), 1);
            last_rd = 1'b1; tick_n(1); last_rd = 1'b0;
            check("R8", "data_ready cleared", int'(data_ready), 0);
            // R1: converter clock period
            check("R1", "adc_clk period", clk_per, tk);
            // R3: start-up plus first tracking
            if (nstart > 0)
                check_rng("R3", "on-to-first-start", st_cyc[0] - on_cyc,
                          (STARTUP + t) * tk, (STARTUP + t + 1) * tk + 3);
            // R5: overlapped tracking, stretched when longer
            if (nstart > 1) begin
                g = st_cyc[1] - st_cyc[0];
                clo = (9 + ((x > 0) ? x - 1 : 0)) * tk;
                chi = (10 + x) * tk + 6;
                lo = imax(clo, t * tk);
                hi = imax(chi, (t + 1) * tk + 3);
                check_rng("R5", "start-to-start gap", g, lo, hi);
            end
        end

        // R2: trigger with no channel enabled is ignored
        ch_enable = '0;
        pulse_sw();
        tick_n(5);
        check("R2", "adc_on with no channels", int'(adc_on), 0);

        // R11: reset in the middle of a sequence
        ch_enable = 8'b0000_1111; prescale = 8'd1; track_time = 4'd3; low_res = 1'b0;
        vec_idx = 9;
        pulse_sw();
        tick_n(120);
        rst_n = 1'b0; tick_n(2);
        check("R11", "adc_on after mid-run reset", int'(adc_on), 0);
        check("R11", "data_ready after mid-run reset", int'(data_ready), 0);
        check("R11", "ch_data after mid-run reset", int'(ch_data == '0), 1);
        check("R11", "last_data after mid-run reset", int'(last_data), 0);
        rst_n = 1'b1;
        tick_n(5);
        check("R11", "stays idle after reset", int'(busy), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule